// File: doc/BRIEF.md
# Dual-Clock Byte Output FIFO with Drain Flag

This block moves bytes from a producer running on one clock to a consumer running on a second clock with no fixed relation to the first. The producer pushes one byte per write-clock cycle with a single-cycle strobe. Before each push it polls a full flag. The consumer sees the oldest stored byte directly on its data output whenever its empty flag is low, and acknowledges it with a single-cycle read strobe.

Each side keeps a binary pointer one bit wider than the storage address. A Gray-coded copy of each pointer crosses into the other domain through a two-stage synchronizer. The write side also keeps a registered "drained" flag. It comes from comparing the write-side occupancy estimate with zero, it comes out of reset high, and it falls once data is held. A producer can use its return to high as an interrupt condition meaning that all pushed bytes have left. The storage depth is a parameter, checked at elaboration. A second parameter removes the drained flag; the output is then held high.

Top module: `xclk_byte_fifo`

## Requirements
- R1: Every accepted byte (8 bits) appears on `rd_byte` exactly once, in the order it was pushed, for any relation between the two clock periods.
- R2: `DEPTH` must be a power of two no smaller than 16, or elaboration fails. Exactly `DEPTH` bytes are accepted before `wr_full` rises. `wr_full` stays low after `DEPTH`-1 pushes.
- R3: A push while `wr_full` is high is dropped. It changes neither the write pointer nor the byte sequence seen by the reader.
- R4: `rd_empty` is high when no unread byte is visible to the read side. A read strobe while `rd_empty` is high is ignored and does not move the read pointer.
- R5: Whenever `rd_empty` is low, `rd_byte` shows the oldest unread byte and holds it until a read strobe. A read strobe moves the output to the next byte.
- R6: `wr_drained` is a register in the write domain. It is 1 after reset, and it is never 1 in a cycle where `wr_full` is 1.
- R7: `wr_drained` falls within 2 write cycles after the first push into an empty FIFO. It returns to 1 within 5 write cycles once the reader has taken the last byte and `rd_empty` is high.
- R8: The Gray pointer passed across each domain boundary changes by at most one bit per clock of its own domain.
- R9: With `DRAIN_FLAG_EN` = 0, `wr_drained` is held at 1 regardless of pushes.
- R10: After reset, `wr_full` is 0 and `rd_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-side asynchronous active-low reset |
| wr_push | input | 1 | Single-cycle push strobe |
| wr_byte | input | 8 | Byte to push |
| wr_full | output | 1 | FIFO holds `DEPTH` bytes; pushes are dropped |
| wr_drained | output | 1 | Registered write-side empty indication, reset high |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-side asynchronous active-low reset |
| rd_pop | input | 1 | Single-cycle read acknowledge strobe |
| rd_byte | output | 8 | Oldest unread byte (valid while `rd_empty` is low) |
| rd_empty | output | 1 | No unread byte visible on the read side |

## Verification
The bench runs with a 125 MHz write clock and a read clock of unrelated period. It drives a table of bursts: an ascending burst that fills the FIFO to capacity, a single byte, a descending run, an alternating bit pattern and a partial stride. The single byte isolates the drain-flag timing. The full burst separates off-by-one capacity errors from correct full detection. The inverted and alternating values expose swapped or stuck data bits and out-of-order reads. A concurrent stream with irregular gaps on both sides then checks byte order and count across the Gray-pointer crossing against a reference queue. Directed cases push into a full FIFO, strobe reads while empty, and build a second instance with the drain flag disabled.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;

    localparam int XF_WIDTH = 8;
    localparam int XF_MIN_DEPTH = 16;

    typedef logic [XF_WIDTH-1:0] xf_byte_t;

    // Legal depth: a power of two no smaller than the minimum.
    function automatic bit xf_depth_ok(input int d);
        return (d >= XF_MIN_DEPTH) && ((d & (d - 1)) == 0);
    endfunction

endpackage

// File: rtl/xfifo_sync2.sv
module xfifo_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;

endmodule

// File: rtl/xfifo_store.sv
module xfifo_store
    import xfifo_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  xf_byte_t      wdata,
    input  logic [AW-1:0] raddr,
    output xf_byte_t      rdata
);

    xf_byte_t mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (wen) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Unregistered read: the head entry is visible without a read cycle.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl #(
    parameter  int DEPTH    = 16,
    parameter  bit DRAIN_EN = 1'b1,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] rgray_sync,
    output logic [PW-1:0] wptr_bin,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          wen,
    output logic          full,
    output logic          drained
);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          drained;
    } wr_state_t;

    localparam wr_state_t WR_RESET = '{bin: '0, gray: '0, drained: 1'b1};

    wr_state_t     st_d, st_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] occ;
    logic          accept;

    always_comb begin
        // Gray to binary: bit i is the parity of gray bits i and above.
        for (int i = 0; i < PW; i++) begin
            rbin[i] = ^(rgray_sync >> i);
        end
        occ    = st_q.bin - rbin;
        full   = (occ == PW'(DEPTH));
        accept = push && !full;

        st_d = st_q;
        if (accept) begin
            st_d.bin = st_q.bin + 1'b1;
        end
        st_d.gray    = st_d.bin ^ (st_d.bin >> 1);
        st_d.drained = (occ == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign wptr_bin = st_q.bin;
    assign wgray    = st_q.gray;
    assign waddr    = st_q.bin[AW-1:0];
    assign wen      = accept;

    generate
        if (DRAIN_EN) begin : g_drain
            assign drained = st_q.drained;
        end else begin : g_no_drain
            assign drained = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic [PW-1:0] wgray_sync,
    output logic [PW-1:0] rptr_bin,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic          empty
);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } rd_state_t;

    rd_state_t     st_d, st_q;
    logic [PW-1:0] wbin;
    logic          accept;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin[i] = ^(wgray_sync >> i);
        end
        empty  = (wbin == st_q.bin);
        accept = pop && !empty;

        st_d = st_q;
        if (accept) begin
            st_d.bin = st_q.bin + 1'b1;
        end
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rptr_bin = st_q.bin;
    assign rgray    = st_q.gray;
    assign raddr    = st_q.bin[AW-1:0];

endmodule

// File: rtl/xclk_byte_fifo.sv
module xclk_byte_fifo
    import xfifo_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter bit DRAIN_FLAG_EN = 1'b1
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic       wr_push,
    input  logic [7:0] wr_byte,
    output logic       wr_full,
    output logic       wr_drained,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    input  logic       rd_pop,
    output logic [7:0] rd_byte,
    output logic       rd_empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    generate
        if (!xf_depth_ok(DEPTH)) begin : g_bad_depth
            $error("xclk_byte_fifo: DEPTH must be a power of two and at least 16");
        end
    endgenerate

    logic [PW-1:0] wptr_bin, wgray, rgray_ws;
    logic [PW-1:0] rptr_bin, rgray, wgray_rs;
    logic [AW-1:0] waddr, raddr;
    logic          wen;

    xfifo_wr_ctl #(
        .DEPTH    (DEPTH),
        .DRAIN_EN (DRAIN_FLAG_EN)
    ) u_wr_ctl (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .push       (wr_push),
        .rgray_sync (rgray_ws),
        .wptr_bin   (wptr_bin),
        .wgray      (wgray),
        .waddr      (waddr),
        .wen        (wen),
        .full       (wr_full),
        .drained    (wr_drained)
    );

    xfifo_sync2 #(.W(PW)) u_rptr_to_wr (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .din   (rgray),
        .dout  (rgray_ws)
    );

    xfifo_sync2 #(.W(PW)) u_wptr_to_rd (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .din   (wgray),
        .dout  (wgray_rs)
    );

    xfifo_rd_ctl #(.DEPTH(DEPTH)) u_rd_ctl (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .pop        (rd_pop),
        .wgray_sync (wgray_rs),
        .rptr_bin   (rptr_bin),
        .rgray      (rgray),
        .raddr      (raddr),
        .empty      (rd_empty)
    );

    xfifo_store #(.DEPTH(DEPTH)) u_store (
        .wclk  (wr_clk),
        .wen   (wen),
        .waddr (waddr),
        .wdata (wr_byte),
        .raddr (raddr),
        .rdata (rd_byte)
    );

endmodule

// File: rtl/xfifo_checks.sv
module xfifo_checks #(
    parameter int PW       = 5,
    parameter bit DRAIN_EN = 1'b1
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          wr_push,
    input logic          wr_full,
    input logic          wr_drained,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          rd_pop,
    input logic          rd_empty,
    input logic [7:0]    rd_byte,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray
);

    assert_wgray_step_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    assert_rgray_step_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    assert_push_full_ignored_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_push && wr_full) |=> (wptr == $past(wptr)));

    assert_pop_empty_ignored_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_pop && rd_empty) |=> (rptr == $past(rptr)));

    assert_full_not_drained_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_full |-> (!wr_drained || !DRAIN_EN));

    assert_head_held_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n || !wr_rst_n)
        (!rd_empty && !rd_pop) |=> $stable(rd_byte));

endmodule

bind xclk_byte_fifo xfifo_checks #(
    .PW       (PW),
    .DRAIN_EN (DRAIN_FLAG_EN)
) u_xfifo_checks (
    .wr_clk     (wr_clk),
    .wr_rst_n   (wr_rst_n),
    .wr_push    (wr_push),
    .wr_full    (wr_full),
    .wr_drained (wr_drained),
    .rd_clk     (rd_clk),
    .rd_rst_n   (rd_rst_n),
    .rd_pop     (rd_pop),
    .rd_empty   (rd_empty),
    .rd_byte    (rd_byte),
    .wptr       (wptr_bin),
    .rptr       (rptr_bin),
    .wgray      (wgray),
    .rgray      (rgray)
);

// File: tb/xclk_byte_fifo_bench.sv
`timescale 1ns/1ps
module xclk_byte_fifo_bench;

    localparam int DEPTH = 16;
    localparam int NV    = 5;
    // Each vector: {burst length, first byte, byte step, expected wr_full after burst}
    localparam logic [31:0] VECS [NV] = '{
        {8'd16, 8'h00, 8'h01, 8'd1},
        {8'd1,  8'hA5, 8'h00, 8'd0},
        {8'd7,  8'hFF, 8'hFF, 8'd0},
        {8'd12, 8'h55, 8'hFF, 8'd0},
        {8'd16, 8'h80, 8'h11, 8'd1}
    };

    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    always #4    wr_clk = ~wr_clk;
    always #5.65 rd_clk = ~rd_clk;

    logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic       wr_push = 1'b0, rd_pop = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       wr_full, wr_drained, rd_empty;
    logic [7:0] rd_byte;

    logic       wr_push2 = 1'b0;
    logic       rd_pop2  = 1'b0;
    logic       wr_full2, wr_drained2, rd_empty2;
    logic [7:0] rd_byte2;

    xclk_byte_fifo #(.DEPTH(DEPTH)) u_xclk_byte_fifo (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_push(wr_push), .wr_byte(wr_byte),
        .wr_full(wr_full), .wr_drained(wr_drained),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_pop(rd_pop),
        .rd_byte(rd_byte), .rd_empty(rd_empty)
    );

    xclk_byte_fifo #(.DEPTH(DEPTH), .DRAIN_FLAG_EN(1'b0)) u_xclk_byte_fifo_nodrain (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_push(wr_push2), .wr_byte(8'h5A),
        .wr_full(wr_full2), .wr_drained(wr_drained2),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_pop(rd_pop2),
        .rd_byte(rd_byte2), .rd_empty(rd_empty2)
    );

    logic [7:0] ref_q [$];
    int n_cmp = 0;
    int n_mis = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    endtask

    // Called at a write-clock falling edge; returns at one.
    task automatic push_byte(input logic [7:0] b);
        while (wr_full) @(negedge wr_clk);
        wr_byte = b;
        wr_push = 1'b1;
        ref_q.push_back(b);
        @(negedge wr_clk);
        wr_push = 1'b0;
    endtask

    // Called at a read-clock falling edge; returns at one.
    task automatic pop_expect();
        logic [7:0] exp;
        while (rd_empty) @(negedge rd_clk);
        exp = ref_q.pop_front();
        chk("R1 R5 head byte order", {24'd0, rd_byte}, {24'd0, exp});
        rd_pop = 1'b1;
        @(negedge rd_clk);
        rd_pop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        n_mis++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        report();
    end

    initial begin
        repeat (4) @(negedge wr_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        @(negedge wr_clk);

        // R10 / R6 reset state
        chk("R10 reset wr_full", wr_full, 0);
        chk("R10 reset rd_empty", rd_empty, 1);
        chk("R6 reset wr_drained", wr_drained, 1);

        // Vector table: burst, then drain, checking flags
        for (int v = 0; v < NV; v++) begin
            logic [7:0] len, b, step, efull;
            {len, b, step, efull} = VECS[v];
            for (int k = 0; k < len; k++) begin
                push_byte(b);
                b = b + step;
            end
            chk("R2 wr_full after burst", wr_full, efull);
            repeat (2) @(negedge wr_clk);
            chk("R7 drained falls after push", wr_drained, 0);
            @(negedge rd_clk);
            for (int k = 0; k < len; k++) pop_expect();
            repeat (4) @(negedge rd_clk);
            chk("R4 empty after drain", rd_empty, 1);
            repeat (5) @(negedge wr_clk);
            chk("R7 drained back to 1", wr_drained, 1);
        end

        // R2 capacity edge and R3 push while full
        @(negedge wr_clk);
        for (int k = 0; k < DEPTH - 1; k++) push_byte(8'hC0 + 8'(k));
        chk("R2 not full at DEPTH-1", wr_full, 0);
        push_byte(8'hCF);
        chk("R2 full at DEPTH", wr_full, 1);
        wr_byte = 8'hEE;
        wr_push = 1'b1;
        repeat (3) @(negedge wr_clk);
        wr_push = 1'b0;
        chk("R3 still full after dropped push", wr_full, 1);
        @(negedge rd_clk);
        for (int k = 0; k < DEPTH; k++) pop_expect();
        repeat (6) @(negedge rd_clk);
        chk("R3 no extra byte after full push", rd_empty, 1);

        // R4 pop while empty, then one byte
        rd_pop = 1'b1;
        repeat (3) @(negedge rd_clk);
        rd_pop = 1'b0;
        @(negedge wr_clk);
        push_byte(8'h3C);
        repeat (6) @(negedge rd_clk);
        chk("R4 byte visible after ignored pops", rd_empty, 0);
        chk("R4 head is new byte", {24'd0, rd_byte}, 32'h3C);
        repeat (3) @(negedge rd_clk);
        chk("R5 head held without pop", {24'd0, rd_byte}, 32'h3C);
        pop_expect();
        repeat (3) @(negedge rd_clk);
        chk("R4 empty after single pop", rd_empty, 1);

        // Concurrent stream with gaps on both sides
        fork
            begin
                @(negedge wr_clk);
                for (int k = 0; k < 120; k++) begin
                    push_byte(8'(k * 7 + 3));
                    if (k % 5 == 0) @(negedge wr_clk);
                end
            end
            begin
                @(negedge rd_clk);
                for (int k = 0; k < 120; k++) begin
                    pop_expect();
                    if (k % 3 == 0) repeat (2) @(negedge rd_clk);
                end
            end
        join
        repeat (6) @(negedge rd_clk);
        chk("R1 stream count, reader empty", rd_empty, 1);
        chk("R1 stream count, reference drained", ref_q.size(), 0);
        repeat (5) @(negedge wr_clk);
        chk("R7 drained after stream", wr_drained, 1);

        // R9 disabled drain flag
        chk("R9 drained high at idle", wr_drained2, 1);
        wr_push2 = 1'b1;
        @(negedge wr_clk);
        wr_push2 = 1'b0;
        repeat (4) @(negedge wr_clk);
        chk("R9 drained held high with data", wr_drained2, 1);
        repeat (4) @(negedge rd_clk);
        chk("R9 byte accepted", rd_empty2, 0);
        chk("R9 byte value", {24'd0, rd_byte2}, 32'h5A);

        report();
    end

endmodule